// File: doc/BRIEF.md
# Windowed Watchdog Timer with Sleep Wakeup

This block is a down-counting watchdog with a refresh window. The counter starts from a programmable reload value and loses one per clock while it runs. Software may refresh it only once the count has dropped to or below a programmable threshold. A refresh that comes too early is a window violation. A violation is handled the same way as the count running out. Either event produces one of two outcomes: a one-cycle reset request, or a sticky timeout interrupt. A control bit selects which.

A second sticky interrupt serves a sleeping processor. When the count falls through the threshold while the sleeping input is high, the wakeup interrupt fires, provided it is enabled. The processor can then wake and refresh in time. Counting stops and the value is kept in two cases: while the low-power freeze input and the sleeping input are both high, and while the programming input is high. When the programming input falls, the whole block returns to its reset state. Registers are written through a simple valid/address/data port.

Top module: `win_watchdog`

## Requirements
- R1: After reset the counter holds the reload reset value, the expiry action is reset request, the wakeup enable is off, and `rst_req`, `tmo_irq` and `wake_irq` are low.
- R2: While running, the counter falls by one per clock. In the cycle it reads zero, the expiry action fires at the next clock edge and the counter is loaded with the reload value. Events therefore recur every reload+1 cycles. A reload value of zero is loaded as one.
- R3: A refresh with the count at or below the threshold (equal included) reloads the counter and causes no event.
- R4: A refresh with the count above the threshold is a violation. It fires the expiry action at the next edge and reloads the counter.
- R5: In reset-request mode (control bit 0 = 0), each event drives `rst_req` high for exactly one cycle.
- R6: In interrupt mode (control bit 0 = 1), events set `tmo_irq` and never pulse `rst_req`.
- R7: Both interrupts stay high until cleared. Writing 1 to bit 0 of the clear register (address 3) clears `tmo_irq`. Writing 1 to bit 1 clears `wake_irq`. Each bit touches only its own interrupt, and a set in the same cycle wins over a clear.
- R8: `wake_irq` is set when the count steps from above the threshold to at or below it, but only while `sleeping` is high and the wake enable (control bit 1) is set.
- R9: The wakeup interrupt fires at most once per crossing. Only a reload to a value above the threshold arms it again.
- R10: While `lp_freeze` and `sleeping` are both high the counter holds its value. With `lp_freeze` high alone it keeps counting.
- R11: While `prog_hold` is high the counter holds, refresh strobes are ignored and the interrupts keep their state.
- R12: On the clock edge after `prog_hold` falls, every register, interrupt and the counter return to their reset values.
- R13: Register writes take effect at the next edge. Address 0 is the reload value, address 1 the threshold, address 2 the control (bit 0 interrupt mode, bit 1 wake enable), and address 3 the clear strobes. A new reload value is used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| refresh | input | 1 | Refresh strobe, one cycle |
| sleeping | input | 1 | Processor is asleep |
| lp_freeze | input | 1 | Low-power freeze mode is active |
| prog_hold | input | 1 | Programming in progress: pause, then restart on release |
| rst_req | output | 1 | One-cycle reset request |
| tmo_irq | output | 1 | Sticky timeout interrupt |
| wake_irq | output | 1 | Sticky wakeup interrupt |

## Verification
The assertions check on every cycle the properties that need no history: the reset request lasts one cycle and only appears in reset-request mode, the interrupts stay set unless cleared or restarted, a wakeup rise always has sleep and enable behind it, and the count stays still while paused. Other behaviours are visible only as event timing, so only the bench scenarios show them. These are the reload+1 period, the equal-to-threshold refresh boundary, an early refresh, re-arming after a reload, the delay caused by a sleeping freeze, a new reload value, and the complete restart after programming.

// File: rtl/wdw_pkg.sv
// Shared register selects, bit positions and the expiry action type.
package wdw_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_RELOAD = 2'd0,
        REG_THRESH = 2'd1,
        REG_CTRL   = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_WAKE_BIT = 1;
    localparam int CLR_TMO_BIT   = 0;
    localparam int CLR_WAKE_BIT  = 1;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_IRQ   = 1'b1
    } expiry_act_e;
endpackage

// File: rtl/wdw_regs.sv
// Register file of the watchdog: reload, threshold, control bits and
// one-cycle clear strobes. Assumes the data width is at least 2 bits.
module wdw_regs #(
    parameter int CNT_W      = 16,
    parameter int RELOAD_RST = 1000,
    parameter int THRESH_RST = 400
) (
    input  logic                       clk,
    input  logic                       rst_eff_n,
    input  logic                       wr_valid,
    input  logic [wdw_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [CNT_W-1:0]           reload_o,
    output logic [CNT_W-1:0]           thresh_o,
    output wdw_pkg::expiry_act_e       act_o,
    output logic                       wake_en_o,
    output logic                       clr_tmo_o,
    output logic                       clr_wake_o
);
    import wdw_pkg::*;

    localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(RELOAD_RST);
    localparam logic [CNT_W-1:0] THRESH_INIT = CNT_W'(THRESH_RST);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] thresh_q;
    expiry_act_e      act_q;
    logic             wake_en_q;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(wr_addr);

    // Store the configuration registers on a write.
    always_ff @(posedge clk) begin
        if (!rst_eff_n) begin
            reload_q  <= RELOAD_INIT;
            thresh_q  <= THRESH_INIT;
            act_q     <= ACT_RESET;
            wake_en_q <= 1'b0;
        end else if (wr_valid) begin
            case (sel)
                REG_RELOAD: reload_q <= wr_data;
                REG_THRESH: thresh_q <= wr_data;
                REG_CTRL: begin
                    act_q     <= expiry_act_e'(wr_data[CTRL_MODE_BIT]);
                    wake_en_q <= wr_data[CTRL_WAKE_BIT];
                end
                default: ;
            endcase
        end
    end

    // Decode the write-one-to-clear strobes.
    always_comb begin
        clr_tmo_o  = wr_valid && (sel == REG_CLEAR) && wr_data[CLR_TMO_BIT];
        clr_wake_o = wr_valid && (sel == REG_CLEAR) && wr_data[CLR_WAKE_BIT];
    end

    assign reload_o  = reload_q;
    assign thresh_o  = thresh_q;
    assign act_o     = act_q;
    assign wake_en_o = wake_en_q;
endmodule

// File: rtl/wdw_core.sv
// Down counter with the refresh window. Produces an event on expiry or an
// early refresh, and a crossing flag when the count steps through the
// threshold. Assumes run_i already combines every pause condition.
module wdw_core #(
    parameter int CNT_W      = 16,
    parameter int RELOAD_RST = 1000,
    parameter int THRESH_RST = 400
) (
    input  logic             clk,
    input  logic             rst_eff_n,
    input  logic             run_i,
    input  logic             refresh_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o,
    output logic             cross_o
);
    localparam int               RST_LOAD   = (RELOAD_RST == 0) ? 1 : RELOAD_RST;
    localparam logic [CNT_W-1:0] LOAD_INIT  = CNT_W'(RST_LOAD);
    localparam logic             ARMED_INIT = (RST_LOAD > THRESH_RST);

    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_dec;
    logic             in_window;
    logic             legal_ref;
    logic             violation;
    logic             expire;
    logic             step;
    logic             do_load;

    // Classify this cycle: refresh, violation, expiry or plain decrement.
    always_comb begin
        load_val  = (reload_i == '0) ? CNT_W'(1) : reload_i;
        count_dec = count_q - CNT_W'(1);
        in_window = (count_q <= thresh_i);
        legal_ref = run_i && refresh_i && in_window;
        violation = run_i && refresh_i && !in_window;
        expire    = run_i && !refresh_i && (count_q == '0);
        step      = run_i && !refresh_i && (count_q != '0);
        do_load   = legal_ref || violation || expire;
        cross_o   = step && armed_q && (count_dec <= thresh_i);
        event_o   = violation || expire;
    end

    // Advance, reload or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_eff_n) begin
            count_q <= LOAD_INIT;
        end else if (do_load) begin
            count_q <= load_val;
        end else if (step) begin
            count_q <= count_dec;
        end
    end

    // Track whether the next threshold crossing may still be reported.
    always_ff @(posedge clk) begin
        if (!rst_eff_n) begin
            armed_q <= ARMED_INIT;
        end else if (do_load) begin
            armed_q <= (load_val > thresh_i);
        end else if (cross_o) begin
            armed_q <= 1'b0;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/wdw_irq.sv
// Turns counter events into the reset request or the timeout interrupt,
// and threshold crossings into the wakeup interrupt. Sets win over clears.
module wdw_irq (
    input  logic                 clk,
    input  logic                 rst_eff_n,
    input  logic                 event_i,
    input  logic                 cross_i,
    input  wdw_pkg::expiry_act_e act_i,
    input  logic                 wake_en_i,
    input  logic                 sleep_i,
    input  logic                 clr_tmo_i,
    input  logic                 clr_wake_i,
    output logic                 rst_req_o,
    output logic                 tmo_irq_o,
    output logic                 wake_irq_o
);
    import wdw_pkg::*;

    logic rst_req_q;
    logic tmo_q;
    logic wake_q;
    logic tmo_set;
    logic wake_set;

    // Pick the action an event asks for.
    always_comb begin
        tmo_set  = event_i && (act_i == ACT_IRQ);
        wake_set = cross_i && sleep_i && wake_en_i;
    end

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_eff_n) rst_req_q <= 1'b0;
        else            rst_req_q <= event_i && (act_i == ACT_RESET);
    end

    // Hold the timeout interrupt until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_eff_n)     tmo_q <= 1'b0;
        else if (tmo_set)   tmo_q <= 1'b1;
        else if (clr_tmo_i) tmo_q <= 1'b0;
    end

    // Hold the wakeup interrupt until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_eff_n)      wake_q <= 1'b0;
        else if (wake_set)   wake_q <= 1'b1;
        else if (clr_wake_i) wake_q <= 1'b0;
    end

    assign rst_req_o  = rst_req_q;
    assign tmo_irq_o  = tmo_q;
    assign wake_irq_o = wake_q;
endmodule

// File: rtl/win_watchdog.sv
// Top of the windowed watchdog. Builds the pause and restart controls from
// the programming, freeze and sleep inputs and wires the three parts.
// Assumes all inputs are synchronous to clk.
module win_watchdog #(
    parameter int CNT_W      = 16,
    parameter int RELOAD_RST = 1000,
    parameter int THRESH_RST = 400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [wdw_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    input  logic                       refresh,
    input  logic                       sleeping,
    input  logic                       lp_freeze,
    input  logic                       prog_hold,
    output logic                       rst_req,
    output logic                       tmo_irq,
    output logic                       wake_irq
);
    import wdw_pkg::*;

    logic             prog_d;
    logic             restart;
    logic             rst_eff_n;
    logic             run;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] thresh_val;
    expiry_act_e      act_sel;
    logic             wake_en;
    logic             clr_tmo;
    logic             clr_wake;
    logic [CNT_W-1:0] count_val;
    logic             cnt_event;
    logic             cnt_cross;

    // Remember the programming input to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_d <= 1'b0;
        else        prog_d <= prog_hold;
    end

    // Restart on the fall of programming; pause while programming or asleep in freeze.
    always_comb begin
        restart   = prog_d && !prog_hold;
        rst_eff_n = rst_n && !restart;
        run       = !prog_hold && !(lp_freeze && sleeping);
    end

    wdw_regs #(
        .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST), .THRESH_RST(THRESH_RST)
    ) regs_i (
        .clk(clk), .rst_eff_n(rst_eff_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .reload_o(reload_val), .thresh_o(thresh_val), .act_o(act_sel),
        .wake_en_o(wake_en), .clr_tmo_o(clr_tmo), .clr_wake_o(clr_wake)
    );

    wdw_core #(
        .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST), .THRESH_RST(THRESH_RST)
    ) core_i (
        .clk(clk), .rst_eff_n(rst_eff_n), .run_i(run), .refresh_i(refresh),
        .reload_i(reload_val), .thresh_i(thresh_val),
        .count_o(count_val), .event_o(cnt_event), .cross_o(cnt_cross)
    );

    wdw_irq irq_i (
        .clk(clk), .rst_eff_n(rst_eff_n),
        .event_i(cnt_event), .cross_i(cnt_cross), .act_i(act_sel),
        .wake_en_i(wake_en), .sleep_i(sleeping),
        .clr_tmo_i(clr_tmo), .clr_wake_i(clr_wake),
        .rst_req_o(rst_req), .tmo_irq_o(tmo_irq), .wake_irq_o(wake_irq)
    );
endmodule

// File: rtl/win_watchdog_chk.sv
// Property checker for win_watchdog, attached by bind below.
module win_watchdog_chk #(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 prog_hold,
    input logic                 lp_freeze,
    input logic                 sleeping,
    input logic                 rst_req,
    input logic                 tmo_irq,
    input logic                 wake_irq,
    input logic [CNT_W-1:0]     count_val,
    input wdw_pkg::expiry_act_e act_sel,
    input logic                 wake_en,
    input logic                 clr_tmo,
    input logic                 clr_wake,
    input logic                 restart
);
    import wdw_pkg::*;

    AST_RSTREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R5

    AST_RSTREQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(act_sel == ACT_RESET)); // R6

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_irq && !clr_tmo && !restart) |=> tmo_irq); // R7

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !clr_wake && !restart) |=> wake_irq); // R7

    AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> $past(sleeping && wake_en)); // R8

    AST_HOLD_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_freeze && sleeping && !restart) |=> $stable(count_val)); // R10

    AST_HOLD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        prog_hold |=> $stable(count_val)); // R11
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .prog_hold(prog_hold), .lp_freeze(lp_freeze),
    .sleeping(sleeping), .rst_req(rst_req), .tmo_irq(tmo_irq),
    .wake_irq(wake_irq), .count_val(count_val), .act_sel(act_sel),
    .wake_en(wake_en), .clr_tmo(clr_tmo), .clr_wake(clr_wake),
    .restart(restart)
);

// File: tb/win_watchdog_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected events with their cycle, the
// monitor pops and compares each reset pulse and interrupt rise it sees.
module win_watchdog_tb_top;
    localparam int CNT_W = 16;
    localparam int RL    = 20;
    localparam int TH    = 8;
    localparam int K_RST  = 0;
    localparam int K_TMO  = 1;
    localparam int K_WAKE = 2;

    typedef struct {
        int    cyc;
        int    kind;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             refresh = 1'b0;
    logic             sleeping = 1'b0;
    logic             lp_freeze = 1'b0;
    logic             prog_hold = 1'b0;
    logic             rst_req, tmo_irq, wake_irq;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    logic tmo_prev = 1'b0;
    logic wake_prev = 1'b0;
    exp_t exp_q[$];

    win_watchdog #(.CNT_W(CNT_W), .RELOAD_RST(RL), .THRESH_RST(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .refresh(refresh), .sleeping(sleeping),
        .lp_freeze(lp_freeze), .prog_hold(prog_hold),
        .rst_req(rst_req), .tmo_irq(tmo_irq), .wake_irq(wake_irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic expect_ev(input int c, input int k, input string req);
        exp_t e;
        e.cyc = c; e.kind = k; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic sb_check(input int k);
        exp_t e;
        n_tests++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected event at cycle %0d: actual kind %0d expected none", cyc, k);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         e.req, k, cyc, e.kind, e.cyc);
            end
        end
    endtask

    // Monitor: compare every observed event against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (rst_req)                sb_check(K_RST);
            if (tmo_irq && !tmo_prev)   sb_check(K_TMO);
            if (wake_irq && !wake_prev) sb_check(K_WAKE);
        end
        tmo_prev  = tmo_irq;
        wake_prev = wake_irq;
    end

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulse_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input int d);
        wr_valid = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        int L;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        L = cyc;
        mon_en = 1'b1;
        chk(rst_req == 1'b0, "R1", rst_req, 0);
        chk(tmo_irq == 1'b0, "R1", tmo_irq, 0);
        chk(wake_irq == 1'b0, "R1", wake_irq, 0);

        // R2 R5: expiry period of reload+1 with a single-cycle pulse
        expect_ev(L + RL + 1, K_RST, "R2");
        wait_to(L + 1);
        chk(rst_req == 1'b0, "R1", rst_req, 0);
        wait_to(L + RL + 1); L += RL + 1;
        wait_to(L + 1);
        chk(rst_req == 1'b0, "R5", rst_req, 0);

        // R3: refresh with count equal to threshold; R8: awake crossing is silent
        wait_to(L + RL - TH); pulse_refresh(); L += RL - TH + 1;
        expect_ev(L + RL + 1, K_RST, "R3");
        wait_to(L + RL + 1); L += RL + 1;

        // R4: early refresh is a violation
        wait_to(L + 3);
        expect_ev(L + 4, K_RST, "R4");
        pulse_refresh();
        wait_to(L + 4); L += 4;

        // R6 R13: interrupt mode via the control register
        wait_to(L + 1); reg_write(2'd2, 1);
        expect_ev(L + RL + 1, K_TMO, "R6");
        wait_to(L + RL + 1); L += RL + 1;
        chk(rst_req == 1'b0, "R6", rst_req, 0);
        wait_to(L + 2); reg_write(2'd3, 1);
        chk(tmo_irq == 1'b0, "R7", tmo_irq, 0);

        // R8: wakeup on crossing while sleeping and enabled
        wait_to(L + 4); sleeping = 1'b1; reg_write(2'd2, 3);
        expect_ev(L + RL - TH, K_WAKE, "R8");
        expect_ev(L + RL + 1, K_TMO, "R6");
        wait_to(L + RL + 1); L += RL + 1;

        // R7 R9: separate clear bits, one rise per crossing
        wait_to(L + 2); reg_write(2'd3, 2);
        chk(wake_irq == 1'b0, "R7", wake_irq, 0);
        chk(tmo_irq == 1'b1, "R7", tmo_irq, 1);
        expect_ev(L + RL - TH, K_WAKE, "R9");
        wait_to(L + RL - TH + 2); reg_write(2'd3, 2);
        chk(wake_irq == 1'b0, "R7", wake_irq, 0);
        wait_to(L + RL);
        chk(wake_irq == 1'b0, "R9", wake_irq, 0);
        wait_to(L + RL + 1); L += RL + 1;

        // R9 re-arm after reload; R10 sleeping freeze delays expiry by 10
        expect_ev(L + RL - TH, K_WAKE, "R9");
        wait_to(L + 13); reg_write(2'd3, 1);
        wait_to(L + 15); lp_freeze = 1'b1;
        wait_to(L + 25); lp_freeze = 1'b0;
        expect_ev(L + RL + 11, K_TMO, "R10");
        wait_to(L + RL + 11); L += RL + 11;

        // R10: freeze without sleep keeps counting
        wait_to(L + 1); sleeping = 1'b0; lp_freeze = 1'b1;
        wait_to(L + 2); reg_write(2'd3, 1);
        expect_ev(L + RL + 1, K_TMO, "R10");
        wait_to(L + RL + 1); L += RL + 1;
        lp_freeze = 1'b0;

        // R13: new reload value used from the next reload
        wait_to(L + 1); reg_write(2'd0, 12);
        wait_to(L + 3); reg_write(2'd3, 1);
        expect_ev(L + RL + 1, K_TMO, "R13");
        wait_to(L + RL + 1); L += RL + 1;
        wait_to(L + 2); reg_write(2'd3, 1);
        expect_ev(L + 13, K_TMO, "R13");
        wait_to(L + 13); L += 13;

        // R11: programming pauses and ignores refresh; R12 restart on release
        wait_to(L + 2); prog_hold = 1'b1;
        wait_to(L + 5); pulse_refresh();
        wait_to(L + 10);
        chk(tmo_irq == 1'b1, "R11", tmo_irq, 1);
        chk(wake_irq == 1'b1, "R11", wake_irq, 1);
        wait_to(L + 17); prog_hold = 1'b0;
        wait_to(L + 18);
        chk(tmo_irq == 1'b0, "R12", tmo_irq, 0);
        chk(wake_irq == 1'b0, "R12", wake_irq, 0);
        expect_ev(L + 18 + RL + 1, K_RST, "R12");
        wait_to(L + 18 + RL + 3);

        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule